// File: doc/BRIEF.md
# Privilege-Aware Trace and Step-Interrupt Gate

This block sits beside a hart's privilege logic and answers two questions every cycle. First, is trace output allowed at the privilege the hart is running at now? Second, which pending interrupts must be held back while the hart single-steps under an external debugger?

Two inputs decide trace. One is a machine-level trace enable that comes from outside the hart. The other is a supervisor-domain trace permission bit, read from a configuration word. The trace decision is registered, so the trace encoder sees a clean, glitch-free enable.

The interrupt gate is combinational. A full machine debug grant masks every pending interrupt while stepping. A grant that covers only the supervisor domain masks just the interrupts delegated to that domain. Interrupts that trap to machine mode keep flowing.

Top module: `trace_step_gate`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `trace_en_o` is 0.
- R2: The supervisor trace permission is bit 8 of `sd_cfg_i`. No other bit of that word affects `trace_en_o`.
- R3: With privilege code 2'b11 (machine) on `priv_i`, `trace_en_o` after the next clock edge equals `m_trc_en_i`, whatever `sd_dom_i` and the configuration bit hold.
- R4: With a privilege code other than 2'b11 and `sd_dom_i` = 1, `trace_en_o` after the next edge is the OR of `m_trc_en_i` and `sd_cfg_i[8]`.
- R5: With `m_trc_en_i` = 0 and `sd_cfg_i[8]` = 0, `trace_en_o` is 0 after the next edge at every privilege.
- R6: With a privilege code other than 2'b11 and `sd_dom_i` = 0, `trace_en_o` is 0 after the next edge.
- R7: `trace_en_o` changes only at a clock edge. It reflects the inputs sampled at that edge, so a privilege change shows up one cycle later.
- R8: With `step_i` = 1, `step_ie_i` = 0 and `m_dbg_en_i` = 1, `irq_pend_o` is all zeros in the same cycle.
- R9: With `step_i` = 1, `step_ie_i` = 0, `m_dbg_en_i` = 0 and `sd_dbg_ok_i` = 1, `irq_pend_o` = `irq_pend_i & ~irq_deleg_i`. A 1 in `irq_deleg_i` marks an interrupt delegated to the supervisor domain.
- R10: With `step_i` = 0, or `step_ie_i` = 1, or both debug grants at 0, `irq_pend_o` equals `irq_pend_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| sd_dom_i | input | 1 | Hart is executing in the supervisor domain |
| m_trc_en_i | input | 1 | Machine-level trace enable |
| sd_cfg_i | input | CFG_W | Supervisor-domain configuration word; bit 8 permits trace |
| m_dbg_en_i | input | 1 | Full machine debug granted |
| sd_dbg_ok_i | input | 1 | Debug granted for the supervisor domain only |
| step_i | input | 1 | Hart is single-stepping |
| step_ie_i | input | 1 | Interrupts enabled during stepping |
| irq_pend_i | input | NIRQ | Pending interrupt vector |
| irq_deleg_i | input | NIRQ | Supervisor delegation mask |
| trace_en_o | output | 1 | Registered trace enable |
| irq_pend_o | output | NIRQ | Pending vector after step masking |

## Verification
Two things can change in the same cycle: the privilege, which drives the registered trace enable, and the step-mask conditions, which drive the combinational interrupt vector. A dedicated scenario changes both at once, from supervisor to machine with the machine trace enable low while stepping under a supervisor-only grant. It checks the masked vector immediately. It checks the trace enable both before and after the next edge, which confirms that neither path disturbs the other and that trace drops exactly one cycle late.

// File: rtl/trace_step_gate.sv
module trace_step_gate #(
  parameter int NIRQ    = 16,
  parameter int CFG_W   = 32,
  parameter int TRC_BIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       priv_i,
  input  logic             sd_dom_i,
  input  logic             m_trc_en_i,
  input  logic [CFG_W-1:0] sd_cfg_i,
  input  logic             m_dbg_en_i,
  input  logic             sd_dbg_ok_i,
  input  logic             step_i,
  input  logic             step_ie_i,
  input  logic [NIRQ-1:0]  irq_pend_i,
  input  logic [NIRQ-1:0]  irq_deleg_i,
  output logic             trace_en_o,
  output logic [NIRQ-1:0]  irq_pend_o
);

  localparam logic [1:0] PRIV_M = 2'b11;

  logic in_m, sd_trc_ok, trace_d, step_quiet;

  assign in_m      = (priv_i == PRIV_M);
  assign sd_trc_ok = sd_cfg_i[TRC_BIT];
  assign trace_d   = in_m ? m_trc_en_i : (sd_dom_i & (m_trc_en_i | sd_trc_ok));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trace_en_o <= 1'b0;
    else        trace_en_o <= trace_d;

  assign step_quiet = step_i & ~step_ie_i;

  always_comb begin
    irq_pend_o = irq_pend_i;
    if (step_quiet) begin
      if (m_dbg_en_i)       irq_pend_o = '0;
      else if (sd_dbg_ok_i) irq_pend_o = irq_pend_i & ~irq_deleg_i;
    end
  end

  a_r3_machine_follows_mtrc: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'b11) |=> (trace_en_o == $past(m_trc_en_i)));
  a_r5_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_trc_en_i && !sd_cfg_i[TRC_BIT]) |=> !trace_en_o);
  a_r6_outside_domain_off: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i != 2'b11 && !sd_dom_i) |=> !trace_en_o);
  a_r8_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !step_ie_i && m_dbg_en_i) |-> (irq_pend_o == '0));
  a_r9_sd_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !step_ie_i && !m_dbg_en_i && sd_dbg_ok_i)
      |-> ((irq_pend_o & irq_deleg_i) == '0 && (irq_pend_o | irq_deleg_i) == (irq_pend_i | irq_deleg_i)));
  a_r10_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i || step_ie_i || (!m_dbg_en_i && !sd_dbg_ok_i)) |-> (irq_pend_o == irq_pend_i));

endmodule

// File: tb/test_trace_step_gate.sv
module test_trace_step_gate;
  logic clk = 0, rst_n = 0;
  logic [1:0] priv = 0;
  logic sd_dom = 0, mtrc = 0, mdbg = 0, sdok = 0, step = 0, stepie = 0;
  logic [31:0] cfg = 0;
  logic [15:0] pend = 0, deleg = 0;
  logic trace_en;
  logic [15:0] irq_out;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trace_step_gate i_trace_step_gate (
    .clk(clk), .rst_n(rst_n), .priv_i(priv), .sd_dom_i(sd_dom), .m_trc_en_i(mtrc),
    .sd_cfg_i(cfg), .m_dbg_en_i(mdbg), .sd_dbg_ok_i(sdok), .step_i(step),
    .step_ie_i(stepie), .irq_pend_i(pend), .irq_deleg_i(deleg),
    .trace_en_o(trace_en), .irq_pend_o(irq_out));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic trc_case(input logic [1:0] p, input logic sd, input logic mt, input logic [31:0] c,
                          input logic exp, input string req);
    @(negedge clk);
    priv = p; sd_dom = sd; mtrc = mt; cfg = c;
    @(posedge clk); #1;
    chk(trace_en === exp, req, {31'b0, trace_en}, {31'b0, exp});
  endtask

  task automatic irq_case(input logic st, input logic ie, input logic md, input logic so,
                          input logic [15:0] pv, input logic [15:0] dl, input logic [15:0] exp,
                          input string req);
    @(negedge clk);
    step = st; stepie = ie; mdbg = md; sdok = so; pend = pv; deleg = dl;
    #1;
    chk(irq_out === exp, req, {16'b0, irq_out}, {16'b0, exp});
  endtask

  task automatic t_reset;
    #1 chk(trace_en === 1'b0, "R1 in reset", {31'b0, trace_en}, 0);
    priv = 2'b11; mtrc = 1;
    @(negedge clk); rst_n = 1;
    #0.5 chk(trace_en === 1'b0, "R1 after release", {31'b0, trace_en}, 0);
  endtask

  task automatic t_machine;
    trc_case(2'b11, 0, 1, 32'h0,     1, "R3 M mtrc=1");
    trc_case(2'b11, 1, 0, 32'h100,   0, "R3 M mtrc=0 cfg bit set");
    trc_case(2'b11, 1, 1, 32'h0,     1, "R3 M in sd");
  endtask

  task automatic t_sdom;
    trc_case(2'b01, 1, 0, 32'h100, 1, "R4 S cfg bit");
    trc_case(2'b00, 1, 1, 32'h0,   1, "R4 U mtrc");
    trc_case(2'b01, 1, 0, 32'h0,   0, "R4 S neither");
  endtask

  task automatic t_cfg_bits;
    trc_case(2'b01, 1, 0, 32'hFFFF_FEFF, 0, "R2 other bits ignored");
    trc_case(2'b01, 1, 0, 32'h0000_0100, 1, "R2 bit 8 only");
  endtask

  task automatic t_all_off;
    trc_case(2'b11, 1, 0, 32'h0, 0, "R5 M");
    trc_case(2'b01, 1, 0, 32'h0, 0, "R5 S");
    trc_case(2'b00, 1, 0, 32'h0, 0, "R5 U");
  endtask

  task automatic t_outside;
    trc_case(2'b01, 0, 1, 32'h100, 0, "R6 S outside domain");
    trc_case(2'b00, 0, 1, 32'h100, 0, "R6 U outside domain");
  endtask

  task automatic t_registered;
    trc_case(2'b11, 0, 1, 32'h0, 1, "R7 setup");
    @(negedge clk); mtrc = 0;
    #1 chk(trace_en === 1'b1, "R7 holds before edge", {31'b0, trace_en}, 1);
    @(posedge clk); #1;
    chk(trace_en === 1'b0, "R7 drops after edge", {31'b0, trace_en}, 0);
  endtask

  task automatic t_step;
    irq_case(1, 0, 1, 0, 16'hFFFF, 16'h00F0, 16'h0000, "R8 full mask");
    irq_case(1, 0, 1, 1, 16'h1234, 16'h0F0F, 16'h0000, "R8 both grants");
    irq_case(1, 0, 0, 1, 16'hFFFF, 16'h00F0, 16'hFF0F, "R9 delegated masked");
    irq_case(1, 0, 0, 1, 16'hA5A5, 16'h0000, 16'hA5A5, "R9 none delegated");
    irq_case(0, 0, 1, 1, 16'h5A5A, 16'hFFFF, 16'h5A5A, "R10 not stepping");
    irq_case(1, 1, 1, 0, 16'h5A5A, 16'hFFFF, 16'h5A5A, "R10 stepie set");
    irq_case(1, 0, 0, 0, 16'h5A5A, 16'hFFFF, 16'h5A5A, "R10 no grant");
  endtask

  task automatic t_same_cycle;
    trc_case(2'b01, 1, 1, 32'h0, 1, "R4 same-cycle setup");
    @(negedge clk);
    priv = 2'b11; mtrc = 0; step = 1; stepie = 0; mdbg = 0; sdok = 1;
    pend = 16'hC3C3; deleg = 16'h0303;
    #1;
    chk(irq_out === 16'hC0C0, "R9 same cycle", {16'b0, irq_out}, 32'hC0C0);
    chk(trace_en === 1'b1, "R7 same cycle before edge", {31'b0, trace_en}, 1);
    @(posedge clk); #1;
    chk(trace_en === 1'b0, "R3 same cycle after edge", {31'b0, trace_en}, 0);
    chk(irq_out === 16'hC0C0, "R9 same cycle after edge", {16'b0, irq_out}, 32'hC0C0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    #7;
    t_reset();
    t_machine();
    t_sdom();
    t_cfg_bits();
    t_all_off();
    t_outside();
    t_registered();
    t_step();
    t_same_cycle();
    finish_run();
  end
endmodule